// File: doc/BRIEF.md
# Handshake Line Driver for a Byte-Serial Controller Link

This block owns the two handshake outputs that a host drives toward a system-controller microcontroller on a byte-serial link: a session line (transfer in progress) and a per-byte acknowledge line. It also brings the controller's request line into the clock domain and reports whether a request is present. Sequencing logic elsewhere issues abstract commands. The block turns each one into line levels for whichever controller generation the mode input selects.

The two generations differ in two ways. In the newer one, both outputs are active low and every command takes effect at once. In the older one, both outputs are active high, and most commands must wait a fixed number of microseconds before the line moves. While such a wait runs, `busy` is high and new commands are dropped. The wait is counted by a microsecond prescaler derived from the clock frequency parameter. The toggle command is never delayed.

Top module: `hs_line_driver`

## Requirements
- R1: While reset is asserted and after it is released, `busy` is 0, and both lines sit at their negated level for the current mode: 1 when `legacyMode` is 0, and 0 when `legacyMode` is 1.
- R2: `treqN` is active low in both modes. `treqPresent` equals the inverse of `treqN` as sampled two clock edges earlier, using a two-stage synchronizer that resets to "no request".
- R3: When `legacyMode` is 0, both lines are active low. A command is accepted on an edge where `cmdValid` is 1 and `busy` is 0. It changes the lines at that same edge, and `busy` stays 0. Codes: 0 asserts TIP, 1 asserts TIP and TACK, 2 asserts TACK, 3 negates TACK, 4 toggles TACK, 5 negates TIP and TACK.
- R4: When `legacyMode` is 1, both lines are active high: an asserted line reads 1.
- R5: When `legacyMode` is 1, codes 0 and 1 raise `busy` for exactly 450·CLK_HZ/1e6 cycles from the accepting edge. The lines change at the edge where `busy` falls.
- R6: When `legacyMode` is 1, code 2 holds `busy` for 400 µs worth of cycles, and codes 3 and 5 hold it for 300 µs worth. In each case the lines change at the edge where `busy` falls.
- R7: Code 4 inverts the TACK line at the accepting edge in both modes and never raises `busy`.
- R8: A command presented while `busy` is 1 has no effect on the lines or on the wait in progress. Codes 6 and 7 have no effect at any time.
- R9: `portOut` carries TIP at bit 5 and TACK at bit 4, with all other bits 0. `portDir` is 8'h30: bits 5 and 4 are outputs, and bit 3 (request) and every other bit are inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| legacyMode | input | 1 | 1 selects the older generation (active high, delayed edges) |
| cmdValid | input | 1 | Command strobe |
| cmdCode | input | 3 | Command code |
| treqN | input | 1 | Raw request line from the controller, active low |
| busy | output | 1 | A delayed command is pending |
| tipLine | output | 1 | Transfer-in-progress line level |
| tackLine | output | 1 | Byte-acknowledge line level |
| treqPresent | output | 1 | Synchronized request present |
| portOut | output | 8 | Port image of the output lines |
| portDir | output | 8 | Port direction mask, 1 = output |

## Verification
The bench measures each older-mode wait to the cycle. A prescaler that is off by one, or a delay table with two entries swapped, would stretch or shorten `busy` and move the line edge away from where the reference model puts it. It sends toggles and unused codes in the middle of a wait and in both modes. A design that queued commands, or that treated the toggle as a delayed command, would change TACK at the wrong time or hold `busy` high. It also checks the polarity at reset in each mode and the two-edge latency of the request synchronizer. A single-stage synchronizer or an inverted sense would show up as `treqPresent` changing one cycle early or reading the opposite value.

// File: rtl/hs_line_pkg.sv
package hs_line_pkg;

  localparam int PORT_W   = 8;
  localparam int TREQ_BIT = 3;
  localparam int TACK_BIT = 4;
  localparam int TIP_BIT  = 5;

  typedef enum logic [2:0] {
    CMD_TIP_ON    = 3'd0,
    CMD_BOTH_ON   = 3'd1,
    CMD_TACK_ON   = 3'd2,
    CMD_TACK_OFF  = 3'd3,
    CMD_TACK_FLIP = 3'd4,
    CMD_BOTH_OFF  = 3'd5
  } hs_cmd_e;

  // strobes from control to the line registers
  typedef struct packed {
    logic setTip;
    logic clrTip;
    logic setTack;
    logic clrTack;
    logic flipTack;
  } line_strobe_t;

  function automatic line_strobe_t strobesFor(input logic [2:0] code);
    line_strobe_t s;
    s = '0;
    case (code)
      CMD_TIP_ON:    s.setTip = 1'b1;
      CMD_BOTH_ON:   begin s.setTip = 1'b1; s.setTack = 1'b1; end
      CMD_TACK_ON:   s.setTack = 1'b1;
      CMD_TACK_OFF:  s.clrTack = 1'b1;
      CMD_TACK_FLIP: s.flipTack = 1'b1;
      CMD_BOTH_OFF:  begin s.clrTip = 1'b1; s.clrTack = 1'b1; end
      default:       s = '0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/hs_treq_sync.sv
module hs_treq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic treqN,
  output logic treqPresent
);
  logic [STAGES-1:0] syncQ;

  // the line idles high, so reset to "no request"
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[STAGES-2:0], treqN};
  end

  assign treqPresent = ~syncQ[STAGES-1];
endmodule

// File: rtl/hs_line_ctrl.sv
module hs_line_ctrl
  import hs_line_pkg::*;
#(
  parameter int CLK_HZ       = 100_000_000,
  parameter int TIP_ON_US    = 450,
  parameter int TACK_ON_US   = 400,
  parameter int RELEASE_US   = 300
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         legacyMode,
  input  logic         cmdValid,
  input  logic [2:0]   cmdCode,
  output logic         busy,
  output line_strobe_t strobe
);
  localparam int TICKS_RAW    = CLK_HZ / 1_000_000;
  localparam int TICKS_PER_US = (TICKS_RAW < 1) ? 1 : TICKS_RAW;
  localparam int PRE_W        = (TICKS_PER_US < 2) ? 1 : $clog2(TICKS_PER_US);
  localparam int US_MAX_A     = (TIP_ON_US > TACK_ON_US) ? TIP_ON_US : TACK_ON_US;
  localparam int US_MAX       = (US_MAX_A > RELEASE_US) ? US_MAX_A : RELEASE_US;
  localparam int US_W         = $clog2(US_MAX + 1);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICKS_PER_US - 1);

  logic [PRE_W-1:0] preCnt;
  logic [US_W-1:0]  usLeft;
  logic [2:0]       pendCode;
  logic             accept, needsWait, fire;
  logic [US_W-1:0]  waitUs;

  always_comb begin
    case (cmdCode)
      CMD_TIP_ON, CMD_BOTH_ON:   waitUs = US_W'(TIP_ON_US);
      CMD_TACK_ON:               waitUs = US_W'(TACK_ON_US);
      default:                   waitUs = US_W'(RELEASE_US);
    endcase
  end

  assign accept    = cmdValid && !busy && (cmdCode <= 3'd5);
  assign needsWait = legacyMode && (cmdCode != CMD_TACK_FLIP);
  assign fire      = busy && (preCnt == '0) && (usLeft == US_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      preCnt   <= '0;
      usLeft   <= '0;
      pendCode <= '0;
    end else if (busy) begin
      if (preCnt == '0) begin
        preCnt <= PRE_LAST;
        if (usLeft == US_W'(1)) busy <= 1'b0;
        else                    usLeft <= usLeft - US_W'(1);
      end else begin
        preCnt <= preCnt - PRE_W'(1);
      end
    end else if (accept && needsWait) begin
      busy     <= 1'b1;
      preCnt   <= PRE_LAST;
      usLeft   <= waitUs;
      pendCode <= cmdCode;
    end
  end

  always_comb begin
    if (fire)                       strobe = strobesFor(pendCode);
    else if (accept && !needsWait)  strobe = strobesFor(cmdCode);
    else                            strobe = '0;
  end
endmodule

// File: rtl/hs_line_regs.sv
module hs_line_regs
  import hs_line_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              legacyMode,
  input  line_strobe_t      strobe,
  output logic              tipLine,
  output logic              tackLine,
  output logic [PORT_W-1:0] portOut,
  output logic [PORT_W-1:0] portDir
);
  logic tipAct, tackAct;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tipAct  <= 1'b0;
      tackAct <= 1'b0;
    end else begin
      if (strobe.setTip)        tipAct <= 1'b1;
      else if (strobe.clrTip)   tipAct <= 1'b0;
      if (strobe.flipTack)      tackAct <= ~tackAct;
      else if (strobe.setTack)  tackAct <= 1'b1;
      else if (strobe.clrTack)  tackAct <= 1'b0;
    end
  end

  // older generation drives active high, newer active low
  assign tipLine  = legacyMode ? tipAct  : ~tipAct;
  assign tackLine = legacyMode ? tackAct : ~tackAct;

  for (genvar b = 0; b < PORT_W; b++) begin : g_port
    if (b == TIP_BIT) begin : g_tip
      assign portOut[b] = tipLine;
      assign portDir[b] = 1'b1;
    end else if (b == TACK_BIT) begin : g_tack
      assign portOut[b] = tackLine;
      assign portDir[b] = 1'b1;
    end else begin : g_in
      assign portOut[b] = 1'b0;
      assign portDir[b] = 1'b0;
    end
  end
endmodule

// File: rtl/hs_line_driver.sv
module hs_line_driver
  import hs_line_pkg::*;
#(
  parameter int CLK_HZ     = 100_000_000,
  parameter int TIP_ON_US  = 450,
  parameter int TACK_ON_US = 400,
  parameter int RELEASE_US = 300,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        legacyMode,
  input  logic        cmdValid,
  input  logic [2:0]  cmdCode,
  input  logic        treqN,
  output logic        busy,
  output logic        tipLine,
  output logic        tackLine,
  output logic        treqPresent,
  output logic [7:0]  portOut,
  output logic [7:0]  portDir
);
  line_strobe_t strobe;

  hs_line_ctrl #(
    .CLK_HZ(CLK_HZ), .TIP_ON_US(TIP_ON_US),
    .TACK_ON_US(TACK_ON_US), .RELEASE_US(RELEASE_US)
  ) ctrlI (
    .clk(clk), .rstN(rstN), .legacyMode(legacyMode),
    .cmdValid(cmdValid), .cmdCode(cmdCode),
    .busy(busy), .strobe(strobe)
  );

  hs_line_regs regsI (
    .clk(clk), .rstN(rstN), .legacyMode(legacyMode), .strobe(strobe),
    .tipLine(tipLine), .tackLine(tackLine),
    .portOut(portOut), .portDir(portDir)
  );

  hs_treq_sync #(.STAGES(SYNC_STAGES)) syncI (
    .clk(clk), .rstN(rstN), .treqN(treqN), .treqPresent(treqPresent)
  );
endmodule

// File: rtl/hs_line_driver_chk.sv
module hs_line_driver_chk (
  input logic       clk,
  input logic       rstN,
  input logic       legacyMode,
  input logic       cmdValid,
  input logic [2:0] cmdCode,
  input logic       treqN,
  input logic       busy,
  input logic       tipLine,
  input logic       tackLine,
  input logic       treqPresent
);
  logic [1:0] warm;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              warm <= '0;
    else if (warm != 2'd3)  warm <= warm + 2'd1;
  end

  // R2
  treq_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (warm == 2'd3) |-> (treqPresent == !$past(treqN, 2)));

  // R3
  newer_no_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!legacyMode && !busy && cmdValid) |=> !busy);

  // R5
  legacy_wait_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (legacyMode && !busy && cmdValid &&
     (cmdCode == 3'd0 || cmdCode == 3'd1 || cmdCode == 3'd2 ||
      cmdCode == 3'd3 || cmdCode == 3'd5)) |=> busy);

  // R8
  lines_hold_while_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && $stable(legacyMode)) |-> ($stable(tipLine) && $stable(tackLine)));

  // R7
  toggle_now_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!busy && cmdValid && cmdCode == 3'd4) && $stable(legacyMode))
      |-> (tackLine != $past(tackLine)));
endmodule

bind hs_line_driver hs_line_driver_chk chkI (
  .clk(clk), .rstN(rstN), .legacyMode(legacyMode), .cmdValid(cmdValid),
  .cmdCode(cmdCode), .treqN(treqN), .busy(busy), .tipLine(tipLine),
  .tackLine(tackLine), .treqPresent(treqPresent)
);

// File: tb/hs_line_driver_test.sv
module hs_line_driver_test;
  localparam int CLK_HZ = 10_000_000;
  localparam int TPU    = CLK_HZ / 1_000_000;

  logic clk = 1'b0, rstN = 1'b0, legacyMode = 1'b0, cmdValid = 1'b0, treqN = 1'b1;
  logic [2:0] cmdCode = 3'd0;
  logic busy, tipLine, tackLine, treqPresent;
  logic [7:0] portOut, portDir;

  int compared = 0, mismatched = 0;
  string curReq = "R1";

  always #2.5 clk = ~clk;

  hs_line_driver #(.CLK_HZ(CLK_HZ)) uut (
    .clk(clk), .rstN(rstN), .legacyMode(legacyMode), .cmdValid(cmdValid),
    .cmdCode(cmdCode), .treqN(treqN), .busy(busy), .tipLine(tipLine),
    .tackLine(tackLine), .treqPresent(treqPresent),
    .portOut(portOut), .portDir(portDir)
  );

  // behavioural reference
  bit mTip, mTack, mBusy, s1 = 1, s2 = 1;
  int mRemain;
  int mPend;

  task automatic applyCode(input int c);
    case (c)
      0: mTip = 1;
      1: begin mTip = 1; mTack = 1; end
      2: mTack = 1;
      3: mTack = 0;
      4: mTack = !mTack;
      5: begin mTip = 0; mTack = 0; end
      default: ;
    endcase
  endtask

  function automatic int waitFor(input int c);
    if (c <= 1) return 450 * TPU;
    if (c == 2) return 400 * TPU;
    return 300 * TPU;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mTip = 0; mTack = 0; mBusy = 0; mRemain = 0; s1 = 1; s2 = 1;
    end else begin
      s2 = s1; s1 = treqN;
      if (mBusy) begin
        mRemain--;
        if (mRemain == 0) begin applyCode(mPend); mBusy = 0; end
      end else if (cmdValid && cmdCode <= 3'd5) begin
        if (!legacyMode || cmdCode == 3'd4) applyCode(int'(cmdCode));
        else begin mBusy = 1; mPend = int'(cmdCode); mRemain = waitFor(int'(cmdCode)); end
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    bit eTip, eTack;
    eTip  = legacyMode ? mTip  : !mTip;
    eTack = legacyMode ? mTack : !mTack;
    chk(curReq, "tipLine", tipLine, eTip);
    chk(curReq, "tackLine", tackLine, eTack);
    chk(curReq, "busy", busy, mBusy);
    chk("R2", "treqPresent", treqPresent, !s2);
    chk("R9", "portOut", portOut, {2'b00, eTip, eTack, 4'b0000});
    chk("R9", "portDir", portDir, 8'h30);
  end

  task automatic issue(input int c);
    @(negedge clk); #1; cmdValid = 1'b1; cmdCode = 3'(c);
    @(negedge clk); #1; cmdValid = 1'b0;
  endtask

  // issue in the older mode and measure the busy window
  task automatic timedCmd(input int c, input int expCycles, input string req);
    int n = 0;
    bit b;
    @(negedge clk); #1; cmdValid = 1'b1; cmdCode = 3'(c);
    for (int k = 0; k < 10000; k++) begin
      @(negedge clk); b = busy; #1; cmdValid = 1'b0;
      if (b) n++; else break;
    end
    chk(req, "busy window", n, expCycles);
  endtask

  task automatic doReset(input bit mode);
    @(negedge clk); #1; rstN = 1'b0; legacyMode = mode;
    repeat (3) @(negedge clk);
    #1; rstN = 1'b1;
  endtask

  initial begin
    #1000000;
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    // R1 reset in newer mode
    repeat (3) @(negedge clk);
    chk("R1", "tip at reset new", tipLine, 1);
    chk("R1", "tack at reset new", tackLine, 1);
    chk("R1", "busy at reset", busy, 0);
    #1; rstN = 1'b1;
    @(negedge clk);
    chk("R9", "direction", portDir, 8'h30);

    // R3 newer mode commands
    curReq = "R3";
    issue(0);
    chk("R3", "tip asserted low", tipLine, 0);
    chk("R3", "no busy", busy, 0);
    issue(2);  chk("R3", "tack asserted low", tackLine, 0);
    issue(3);  chk("R3", "tack negated", tackLine, 1);
    issue(5);  chk("R3", "tip negated", tipLine, 1);
    issue(1);  chk("R3", "both asserted", {tipLine, tackLine}, 0);
    curReq = "R7";
    issue(4);  chk("R7", "toggle new", tackLine, 1);
    curReq = "R8";
    issue(6);  issue(7);
    chk("R8", "unused codes", {tipLine, tackLine}, 2'b01);

    // R2 request sense and latency
    @(negedge clk); #1; treqN = 1'b0;
    @(negedge clk); chk("R2", "after one edge", treqPresent, 0);
    @(negedge clk); chk("R2", "after two edges", treqPresent, 1);
    #1; treqN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2", "released", treqPresent, 0);

    // older mode
    doReset(1'b1);
    curReq = "R1";
    @(negedge clk);
    chk("R1", "tip at reset legacy", tipLine, 0);
    chk("R1", "tack at reset legacy", tackLine, 0);
    curReq = "R5";
    timedCmd(0, 450 * TPU, "R5");
    chk("R4", "tip active high", tipLine, 1);
    curReq = "R6";
    timedCmd(2, 400 * TPU, "R6");
    chk("R4", "tack active high", tackLine, 1);
    timedCmd(3, 300 * TPU, "R6");
    chk("R6", "tack negated", tackLine, 0);
    curReq = "R7";
    issue(4);
    chk("R7", "toggle legacy", tackLine, 1);
    chk("R7", "toggle no busy", busy, 0);
    curReq = "R6";
    timedCmd(5, 300 * TPU, "R6");
    chk("R6", "both negated", {tipLine, tackLine}, 0);

    // R8 commands during a wait are dropped
    curReq = "R8";
    issue(1);
    repeat (100) @(negedge clk);
    #1; cmdValid = 1'b1; cmdCode = 3'd4;
    @(negedge clk); #1; cmdCode = 3'd5;
    @(negedge clk); #1; cmdValid = 1'b0;
    chk("R8", "busy kept", busy, 1);
    chk("R8", "tack untouched", tackLine, 0);
    while (busy) @(negedge clk);
    chk("R8", "pending wait wins", {tipLine, tackLine}, 2'b11);
    repeat (5) @(negedge clk);
    chk("R8", "no late effect", {tipLine, tackLine}, 2'b11);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule